// File: doc/BRIEF.md
# Packet CRC-16 Checker

This block watches a received packet as it streams past, one 16-bit word per accepted beat, with a start flag on the first word and an end flag on the last. It runs a 16-bit cyclic redundancy check over the packet. The six most significant bits of the opening header word are not included. Every other header bit and every payload bit is included, up to the last word. The last word holds the CRC that the sender transmitted. When that word arrives, the block compares it with the locally computed value. The same pass counts the words, so one verdict covers both the checksum and the packet length.

The block sits after the lane deframer and before any packet store. It gives a one-cycle verdict for each packet:
- a done strobe;
- with that strobe, either a CRC error or a size error, or neither for a good packet.

A start flag that arrives while a packet is still open ends the open packet as a size error. The flagged word then becomes the first word of a new packet.

Top module: `pkt_crc16_chk`

## Requirements
- R1: One cycle after `rst` is sampled high, `pkt_done`, `crc_err` and `size_err` are low and no packet is open.
- R2: The CRC uses generator 0x1021 (x^16+x^12+x^5+1) and a register seeded with 0xFFFF. Bits are processed most significant bit first. The first word contributes only its bits [9:0]; bits [15:10] are skipped, so changing them never alters the verdict. Every following word except the end word contributes all 16 bits.
- R3: The end word carries the received CRC. If it differs from the computed value on a packet of legal size, `crc_err` and `pkt_done` pulse together in the cycle after the end word is accepted.
- R4: A packet of legal size whose end word matches the computed CRC gives a `pkt_done` pulse with both error flags low.
- R5: A packet's size is legal when its word count, start and end words included, is even and between 2 and 138 (276 bytes). Otherwise `size_err` pulses with `pkt_done`, and `crc_err` stays low.
- R6: `pkt_done` pulses only in the cycle after an accepted end word or an abort. `crc_err` is never high in two consecutive cycles.
- R7: A start word accepted while a packet is open aborts the open packet with a `size_err` pulse in the next cycle. That word opens the new packet.
- R8: Beats with `in_valid` high that are not start words are ignored while no packet is open, and give no verdict.
- R9: A word flagged as both start and end is a one-word packet and gives `size_err`.
- R10: Cycles with `in_valid` low inside a packet leave the CRC and the length count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_data` is accepted this cycle |
| in_sop | input | 1 | Accepted word is the first of a packet |
| in_eop | input | 1 | Accepted word is the last of a packet (carries the CRC) |
| in_data | input | 16 | Packet word |
| pkt_done | output | 1 | One-cycle verdict strobe |
| crc_err | output | 1 | CRC mismatch, valid with `pkt_done` |
| size_err | output | 1 | Illegal length or aborted packet, valid with `pkt_done` |

## Verification
Two events can fall in the same cycle: the abort of an open packet and the arrival of a word flagged both start and end. That word ends the old packet and is itself a one-word packet. The bench provokes this by sending such a word in the middle of a packet. Its reference model, built on word queues, expects exactly one `size_err` pulse, with `pkt_done` and no `crc_err`, and the stream that follows must be judged normally.

// File: rtl/pkt_crc16_pkg.sv
package pkt_crc16_pkg;

    localparam int WORD_W = 16;
    localparam int CRC_W  = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CRC_W-1:0]  crc_t;

    localparam crc_t CRC_POLY = 16'h1021;
    localparam crc_t CRC_SEED = 16'hFFFF;

    // One accepted input beat.
    typedef struct packed {
        logic  valid;
        logic  sop;
        logic  eop;
        word_t data;
    } beat_t;

    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,
        VERDICT_GOOD = 2'd1,
        VERDICT_CRC  = 2'd2,
        VERDICT_SIZE = 2'd3
    } verdict_e;

    // Advance the CRC over one word, MSB first, leaving out the top
    // 'skip' bits of the word.
    function automatic crc_t crc_word(crc_t c, word_t d, int skip);
        crc_t r;
        logic fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (i < WORD_W - skip) begin
                fb = r[CRC_W-1] ^ d[i];
                r  = {r[CRC_W-2:0], 1'b0};
                if (fb) r = r ^ CRC_POLY;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pkt_crc16_engine.sv
module pkt_crc16_engine
    import pkt_crc16_pkg::*;
#(
    parameter int SKIP_BITS = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  upd,
    input  word_t data,
    output crc_t  crc_q
);

    crc_t head_next;
    crc_t body_next;
    crc_t crc_r;

    // Pick the header path at elaboration: with no skipped bits the
    // first word is folded in like any other word.
    generate
        if (SKIP_BITS == 0) begin : g_noskip
            always_comb head_next = crc_word(CRC_SEED, data, 0);
        end else begin : g_skip
            always_comb head_next = crc_word(CRC_SEED, data, SKIP_BITS);
        end
    endgenerate

    always_comb body_next = crc_word(crc_r, data, 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_r <= CRC_SEED;
        end else if (load) begin
            crc_r <= head_next;
        end else if (upd) begin
            crc_r <= body_next;
        end
    end

    assign crc_q = crc_r;

endmodule

// File: rtl/pkt_len_tracker.sv
module pkt_len_tracker #(
    parameter int MAX_WORDS = 138,
    parameter int CNT_W     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cont,
    input  logic eop,
    output logic open_q,
    output logic size_ok
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_WORDS + 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] words_now;
    logic             open_r;

    // Word count including the word on the input this cycle.
    always_comb begin
        if (start) begin
            words_now = CNT_W'(1);
        end else if (count_q == SAT) begin
            words_now = SAT;
        end else begin
            words_now = count_q + CNT_W'(1);
        end
    end

    always_comb begin
        size_ok = !words_now[0]
               && (words_now >= CNT_W'(2))
               && (words_now <= CNT_W'(MAX_WORDS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_r  <= 1'b0;
            count_q <= '0;
        end else if (start) begin
            open_r  <= !eop;
            count_q <= words_now;
        end else if (cont) begin
            count_q <= words_now;
            if (eop) open_r <= 1'b0;
        end
    end

    assign open_q = open_r;

endmodule

// File: rtl/pkt_verdict_reg.sv
module pkt_verdict_reg
    import pkt_crc16_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic end_now,
    input  logic abort,
    input  logic size_ok,
    input  logic crc_match,
    output logic pkt_done,
    output logic crc_err,
    output logic size_err
);

    verdict_e v_next;
    verdict_e v_q;

    // Size outranks CRC: an illegal or aborted packet has no
    // meaningful checksum.
    always_comb begin
        if (abort || (end_now && !size_ok)) begin
            v_next = VERDICT_SIZE;
        end else if (end_now) begin
            v_next = crc_match ? VERDICT_GOOD : VERDICT_CRC;
        end else begin
            v_next = VERDICT_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= VERDICT_NONE;
        end else begin
            v_q <= v_next;
        end
    end

    assign pkt_done = (v_q != VERDICT_NONE);
    assign crc_err  = (v_q == VERDICT_CRC);
    assign size_err = (v_q == VERDICT_SIZE);

endmodule

// File: rtl/pkt_crc16_chk.sv
module pkt_crc16_chk
    import pkt_crc16_pkg::*;
#(
    parameter int MAX_BYTES = 276,
    parameter int SKIP_BITS = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [15:0] in_data,
    output logic        pkt_done,
    output logic        crc_err,
    output logic        size_err
);

    localparam int MAX_WORDS = MAX_BYTES / (WORD_W / 8);
    localparam int CNT_W     = $clog2(MAX_WORDS + 2);

    beat_t b;
    logic  pkt_open;
    logic  start;
    logic  abort;
    logic  cont;
    logic  end_now;
    logic  size_ok;
    logic  crc_match;
    crc_t  crc_q;

    assign b = '{valid: in_valid, sop: in_sop, eop: in_eop, data: in_data};

    assign start     = b.valid && b.sop;
    assign abort     = start && pkt_open;
    assign cont      = b.valid && pkt_open && !b.sop;
    assign end_now   = b.valid && b.eop && (start || pkt_open);
    assign crc_match = (crc_q == b.data);

    pkt_crc16_engine #(
        .SKIP_BITS (SKIP_BITS)
    ) u_crc (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .upd   (cont),
        .data  (b.data),
        .crc_q (crc_q)
    );

    pkt_len_tracker #(
        .MAX_WORDS (MAX_WORDS),
        .CNT_W     (CNT_W)
    ) u_len (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cont    (cont),
        .eop     (b.eop),
        .open_q  (pkt_open),
        .size_ok (size_ok)
    );

    pkt_verdict_reg u_verdict (
        .clk       (clk),
        .rst       (rst),
        .end_now   (end_now),
        .abort     (abort),
        .size_ok   (size_ok),
        .crc_match (crc_match),
        .pkt_done  (pkt_done),
        .crc_err   (crc_err),
        .size_err  (size_err)
    );

endmodule

// File: rtl/pkt_crc16_chk_sva.sv
module pkt_crc16_chk_sva (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_sop,
    input logic in_eop,
    input logic active,
    input logic pkt_done,
    input logic crc_err,
    input logic size_err
);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!pkt_done && !crc_err && !size_err && !active));

    // R6
    a_r6_done_needs_end: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> ($past(in_valid) &&
                      ($past(in_eop) || ($past(in_sop) && $past(active)))));

    // R6
    a_r6_crc_pulse: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> !crc_err);

    // R7
    a_r7_abort_size: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && active) |=> (size_err && pkt_done));

    // R8
    a_r8_no_stray_verdict: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sop && !active) |=> !pkt_done);

    // R9
    a_r9_single_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_eop) |=> (size_err && !crc_err));

endmodule

bind pkt_crc16_chk pkt_crc16_chk_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .active   (pkt_open),
    .pkt_done (pkt_done),
    .crc_err  (crc_err),
    .size_err (size_err)
);

// File: tb/pkt_crc16_chk_tb_top.sv
module pkt_crc16_chk_tb_top;

    typedef logic [15:0] wq_t[$];

    localparam int MAXW = 138;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [15:0] in_data = '0;
    logic        pkt_done;
    logic        crc_err;
    logic        size_err;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // Reference model state.
    bit          m_open = 0;
    logic [15:0] m_q[$];
    logic        e_done = 0;
    logic        e_crc  = 0;
    logic        e_size = 0;

    always #2 clk = ~clk;

    pkt_crc16_chk dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_data  (in_data),
        .pkt_done (pkt_done),
        .crc_err  (crc_err),
        .size_err (size_err)
    );

    function automatic logic [15:0] ref_crc(wq_t w);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < w.size(); k++) begin
            for (int bit_i = 15; bit_i >= 0; bit_i--) begin
                if (!(k == 0 && bit_i >= 10)) begin
                    logic fb;
                    fb = c[15] ^ w[k][bit_i];
                    c  = c << 1;
                    if (fb) c = c ^ 16'h1021;
                end
            end
        end
        return c;
    endfunction

    function automatic void model_step(logic v, logic s, logic e, logic [15:0] d);
        e_done = 0; e_crc = 0; e_size = 0;
        if (rst || !v) return;
        if (s) begin
            if (m_open) begin e_done = 1; e_size = 1; end
            m_q.delete();
            m_q.push_back(d);
            m_open = 1;
            if (e) begin e_done = 1; e_size = 1; m_open = 0; end
        end else if (m_open) begin
            if (e) begin
                int n;
                n = m_q.size() + 1;
                e_done = 1;
                if ((n % 2) != 0 || n > MAXW) e_size = 1;
                else if (ref_crc(m_q) != d) e_crc = 1;
                m_open = 0;
            end else begin
                m_q.push_back(d);
            end
        end
    endfunction

    task automatic compare();
        n_chk++;
        if (pkt_done !== e_done || crc_err !== e_crc || size_err !== e_size) begin
            n_bad++;
            $display("FAIL %s: done/crc/size actual=%b%b%b expected=%b%b%b at %0t",
                     cur_req, pkt_done, crc_err, size_err, e_done, e_crc, e_size, $time);
        end
    endtask

    // One cycle: check the outputs produced by the previous beat, then drive.
    task automatic drive(logic v, logic s, logic e, logic [15:0] d);
        @(negedge clk);
        compare();
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
        model_step(v, s, e, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 16'h0);
    endtask

    // n words total: n-1 random words plus the CRC word.
    function automatic wq_t make_pkt(int n);
        wq_t w;
        for (int i = 0; i < n - 1; i++) w.push_back(16'($urandom));
        w.push_back(ref_crc(w));
        return w;
    endfunction

    task automatic send(wq_t w, int gap);
        for (int i = 0; i < w.size(); i++) begin
            drive(1, i == 0, i == w.size() - 1, w[i]);
            if (gap > 0 && i != w.size() - 1 && (i % gap) == 0) idle(1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        wq_t w;
        // R1: reset
        cur_req = "R1";
        idle(3);
        drive(1, 1, 0, 16'h1234);
        @(negedge clk);
        rst = 1'b0;
        m_open = 0; m_q.delete();
        e_done = 0; e_crc = 0; e_size = 0;
        in_valid = 0; in_sop = 0; in_eop = 0;
        idle(2);

        // R4: good packets
        cur_req = "R4";
        send(make_pkt(4), 0); idle(2);
        send(make_pkt(2), 0); idle(1);

        // R3: corrupted CRC word
        cur_req = "R3";
        w = make_pkt(6); w[5] = w[5] ^ 16'h0100;
        send(w, 0); idle(2);
        w = make_pkt(8); w[3] = w[3] ^ 16'h8000;
        send(w, 0); idle(2);

        // R2: top six header bits are outside the CRC
        cur_req = "R2";
        w = make_pkt(6); w[0] = w[0] ^ 16'hFC00;
        send(w, 0); idle(1);
        w = make_pkt(4); w[0] = w[0] ^ 16'h0200;
        send(w, 0); idle(1);
        w = '{16'h0000, 16'h0000};
        w[1] = ref_crc('{16'h0000});
        send(w, 0); idle(1);

        // R5: size limits
        cur_req = "R5";
        send(make_pkt(MAXW), 0); idle(1);
        send(make_pkt(MAXW + 2), 0); idle(1);
        send(make_pkt(3), 0); idle(1);
        w = make_pkt(5); w[4] = w[4] ^ 16'h1;
        send(w, 0); idle(1);

        // R9: one-word packet
        cur_req = "R9";
        drive(1, 1, 1, 16'hABCD); idle(2);

        // R7: abort by a new start, then abort with a one-word packet
        cur_req = "R7";
        drive(1, 1, 0, 16'h1111); drive(1, 0, 0, 16'h2222);
        send(make_pkt(4), 0); idle(1);
        drive(1, 1, 0, 16'h3333);
        drive(1, 1, 1, 16'h4444);
        send(make_pkt(2), 0); idle(2);

        // R8: stray words outside any packet
        cur_req = "R8";
        drive(1, 0, 0, 16'h5555); drive(1, 0, 1, 16'h6666);
        drive(1, 0, 1, 16'h7777); idle(1);
        send(make_pkt(4), 0); idle(1);

        // R10: gaps inside a packet
        cur_req = "R10";
        send(make_pkt(10), 1); idle(1);
        w = make_pkt(10); w[9] = ~w[9];
        send(w, 2); idle(1);

        // R6: pulses last one cycle; mixed random traffic
        cur_req = "R6";
        for (int p = 0; p < 40; p++) begin
            int n;
            n = 1 + int'($urandom_range(0, 40));
            w = make_pkt(n);
            if ($urandom_range(0, 3) == 0) w[n-1] = w[n-1] ^ 16'h0040;
            send(w, int'($urandom_range(0, 3)));
            idle(int'($urandom_range(0, 2)));
        end
        idle(3);
        finish_run();
    end

endmodule